// File: doc/BRIEF.md
# Single-Cycle 32-bit Subset Processor Core

This core runs a nine-instruction 32-bit load/store instruction set and finishes every instruction within one clock cycle. The cycle begins with the program counter addressing an internal instruction memory. The control decoder then reads the instruction fields, the register file delivers both source operands, and the ALU produces a result. By the next rising edge that result has been written back to a register, stored to the internal data memory, or used to choose the next program counter. The supported instructions are load word, store word, add, subtract, AND, OR, signed set-less-than, branch-if-equal and jump.

Before reset is released, a simple loader port fills both memories one word at a time. After that the core runs on its own. Each cycle it presents a trace on its outputs: the current program counter, the register write it is about to commit, and the store it is about to commit. An environment can follow execution through this trace without reaching into the core.

Top module: `sc_cpu_core`

## Requirements
- R1: A synchronous active-high reset sets the program counter to 0. While reset is high, no register write and no core store take place.
- R2: Outside branches and jumps, the program counter advances by 4 every cycle. Instruction memory holds MEM_WORDS words (default 256) and is indexed by PC bits 9..2.
- R3: R-type instructions have opcode 0x00 in bits 31..26. They read rs (bits 25..21) and rt (bits 20..16) and write rd (bits 15..11). The funct field in bits 5..0 selects the operation: 0x20 add, 0x22 subtract, 0x24 AND, 0x25 OR, and 0x2A set-less-than, which writes 1 when rs < rt as signed values and 0 otherwise.
- R4: Load word (opcode 0x23) forms the address rs + sign-extended bits 15..0. It writes the data-memory word at address bits 9..2 into rt.
- R5: Store word (opcode 0x2B) writes rt to data memory at rs + sign-extended bits 15..0 and performs no register write.
- R6: Branch-if-equal (opcode 0x04) compares rs and rt. When they are equal, the next PC is PC+4 + (sign-extended offset << 2). Otherwise the next PC is PC+4. The instruction writes neither a register nor memory.
- R7: Jump (opcode 0x02) sets the next PC to PC+4 bits 31..28 joined with instruction bits 25..0 shifted left by 2.
- R8: Register 0 always reads as zero, and writes to register 0 are dropped. The register-write trace output stays low for such writes.
- R9: An unrecognised opcode, or an R-type instruction with an unrecognised funct, writes no register and no memory, and the PC advances by 4.
- R10: The loader port writes one word per cycle when load_we is high. load_dmem = 1 selects data memory and 0 selects instruction memory, at word index load_addr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| load_we | input | 1 | Loader write strobe |
| load_dmem | input | 1 | Loader target: 1 data memory, 0 instruction memory |
| load_addr | input | 8 | Loader word index |
| load_data | input | 32 | Loader word |
| pc_o | output | 32 | Current program counter |
| rf_we_o | output | 1 | Register write committed at the next edge |
| rf_waddr_o | output | 5 | Destination register of that write |
| rf_wdata_o | output | 32 | Value of that write |
| dmem_we_o | output | 1 | Core store committed at the next edge |
| dmem_addr_o | output | 32 | Byte address of the current memory access |
| dmem_wdata_o | output | 32 | Store data |

## Verification
The trace outputs are combinational from the current program counter. Each instruction's write-back, store and PC therefore appear in the same cycle the instruction is fetched, and its effect on the PC appears one cycle later. Reset is released just after a rising edge, so instruction 0 is already visible at the following falling edge. From then on the monitor takes one expected item per falling edge, which keeps each comparison mid-cycle on settled values. Taken branches and jumps are checked through the PC of the next item, and register contents are checked indirectly through later stores and ALU results that read them.

// File: rtl/sc_cpu_pkg.sv
package sc_cpu_pkg;
    localparam logic [5:0] OPC_RTYPE = 6'h00;
    localparam logic [5:0] OPC_LOAD  = 6'h23;
    localparam logic [5:0] OPC_STORE = 6'h2B;
    localparam logic [5:0] OPC_BEQ   = 6'h04;
    localparam logic [5:0] OPC_JUMP  = 6'h02;

    localparam logic [5:0] FN_ADD = 6'h20;
    localparam logic [5:0] FN_SUB = 6'h22;
    localparam logic [5:0] FN_AND = 6'h24;
    localparam logic [5:0] FN_OR  = 6'h25;
    localparam logic [5:0] FN_SLT = 6'h2A;

    typedef enum logic [2:0] {
        ALU_ADD,
        ALU_SUB,
        ALU_AND,
        ALU_OR,
        ALU_SLT
    } alu_op_e;

    typedef struct packed {
        logic    reg_write;
        logic    dst_is_rd;
        logic    b_is_imm;
        logic    mem_write;
        logic    wb_from_mem;
        logic    branch;
        logic    jump;
        logic    illegal;
        alu_op_e alu_op;
    } ctrl_t;
endpackage

// File: rtl/sc_word_mem.sv
module sc_word_mem #(
    parameter int WORDS = 256,
    parameter int WIDTH = 32,
    localparam int IDX_W = $clog2(WORDS)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  logic [WIDTH-1:0] wdata,
    input  logic [IDX_W-1:0] ridx,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem_d [WORDS];
    logic [WIDTH-1:0] mem_q [WORDS];

    always_comb begin
        mem_d = mem_q;
        if (we) mem_d[widx] = wdata;
    end

    always_ff @(posedge clk) mem_q <= mem_d;

    assign rdata = mem_q[ridx];
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
    parameter int REGS  = 32,
    parameter int WIDTH = 32,
    localparam int AW   = $clog2(REGS)
) (
    input  logic             clk,
    input  logic [AW-1:0]    ra1,
    input  logic [AW-1:0]    ra2,
    output logic [WIDTH-1:0] rd1,
    output logic [WIDTH-1:0] rd2,
    input  logic             we,
    input  logic [AW-1:0]    wa,
    input  logic [WIDTH-1:0] wd
);
    logic [WIDTH-1:0] regs_d [REGS];
    logic [WIDTH-1:0] regs_q [REGS];

    always_comb begin
        regs_d = regs_q;
        if (we && wa != '0) regs_d[wa] = wd;
    end

    always_ff @(posedge clk) regs_q <= regs_d;

    assign rd1 = (ra1 == '0) ? '0 : regs_q[ra1];
    assign rd2 = (ra2 == '0) ? '0 : regs_q[ra2];
endmodule

// File: rtl/sc_alu.sv
module sc_alu
    import sc_cpu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  alu_op_e          op,
    output logic [WIDTH-1:0] y,
    output logic             zero
);
    always_comb begin
        unique case (op)
            ALU_SUB: y = a - b;
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_SLT: y = {{(WIDTH-1){1'b0}}, ($signed(a) < $signed(b))};
            default: y = a + b;
        endcase
    end

    assign zero = (y == '0);
endmodule

// File: rtl/sc_ctrl_dec.sv
module sc_ctrl_dec
    import sc_cpu_pkg::*;
(
    input  logic [5:0] opcode,
    input  logic [5:0] funct,
    output ctrl_t      ctrl
);
    always_comb begin
        ctrl        = '0;
        ctrl.alu_op = ALU_ADD;
        unique case (opcode)
            OPC_RTYPE: begin
                ctrl.reg_write = 1'b1;
                ctrl.dst_is_rd = 1'b1;
                unique case (funct)
                    FN_ADD:  ctrl.alu_op = ALU_ADD;
                    FN_SUB:  ctrl.alu_op = ALU_SUB;
                    FN_AND:  ctrl.alu_op = ALU_AND;
                    FN_OR:   ctrl.alu_op = ALU_OR;
                    FN_SLT:  ctrl.alu_op = ALU_SLT;
                    default: begin
                        ctrl.reg_write = 1'b0;
                        ctrl.illegal   = 1'b1;
                    end
                endcase
            end
            OPC_LOAD: begin
                ctrl.reg_write   = 1'b1;
                ctrl.b_is_imm    = 1'b1;
                ctrl.wb_from_mem = 1'b1;
            end
            OPC_STORE: begin
                ctrl.b_is_imm  = 1'b1;
                ctrl.mem_write = 1'b1;
            end
            OPC_BEQ: begin
                ctrl.branch = 1'b1;
                ctrl.alu_op = ALU_SUB;
            end
            OPC_JUMP: ctrl.jump = 1'b1;
            default:  ctrl.illegal = 1'b1;
        endcase
    end
endmodule

// File: rtl/sc_cpu_core.sv
module sc_cpu_core
    import sc_cpu_pkg::*;
#(
    parameter int MEM_WORDS = 256,
    localparam int IDX_W    = $clog2(MEM_WORDS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_we,
    input  logic             load_dmem,
    input  logic [IDX_W-1:0] load_addr,
    input  logic [31:0]      load_data,
    output logic [31:0]      pc_o,
    output logic             rf_we_o,
    output logic [4:0]       rf_waddr_o,
    output logic [31:0]      rf_wdata_o,
    output logic             dmem_we_o,
    output logic [31:0]      dmem_addr_o,
    output logic [31:0]      dmem_wdata_o
);
    typedef struct packed {
        logic [31:0] pc;
    } state_t;

    state_t s_d, s_q;

    logic [31:0] instr, rs_val, rt_val, imm_sx, alu_b, alu_y, dm_rdata, wb_val;
    logic [31:0] pc_plus4, br_target, jmp_target;
    logic [4:0]  dst;
    logic        alu_zero, taken, core_store, reg_commit;
    ctrl_t       ctrl;

    sc_word_mem #(.WORDS(MEM_WORDS), .WIDTH(32)) u_imem (
        .clk   (clk),
        .we    (load_we && !load_dmem),
        .widx  (load_addr),
        .wdata (load_data),
        .ridx  (s_q.pc[IDX_W+1:2]),
        .rdata (instr)
    );

    sc_ctrl_dec u_dec (
        .opcode (instr[31:26]),
        .funct  (instr[5:0]),
        .ctrl   (ctrl)
    );

    assign dst    = ctrl.dst_is_rd ? instr[15:11] : instr[20:16];
    assign imm_sx = {{16{instr[15]}}, instr[15:0]};

    sc_regfile #(.REGS(32), .WIDTH(32)) u_rf (
        .clk (clk),
        .ra1 (instr[25:21]),
        .ra2 (instr[20:16]),
        .rd1 (rs_val),
        .rd2 (rt_val),
        .we  (reg_commit),
        .wa  (dst),
        .wd  (wb_val)
    );

    assign alu_b = ctrl.b_is_imm ? imm_sx : rt_val;

    sc_alu #(.WIDTH(32)) u_alu (
        .a    (rs_val),
        .b    (alu_b),
        .op   (ctrl.alu_op),
        .y    (alu_y),
        .zero (alu_zero)
    );

    assign core_store = ctrl.mem_write && !rst;

    sc_word_mem #(.WORDS(MEM_WORDS), .WIDTH(32)) u_dmem (
        .clk   (clk),
        .we    ((load_we && load_dmem) || core_store),
        .widx  ((load_we && load_dmem) ? load_addr : alu_y[IDX_W+1:2]),
        .wdata ((load_we && load_dmem) ? load_data : rt_val),
        .ridx  (alu_y[IDX_W+1:2]),
        .rdata (dm_rdata)
    );

    assign wb_val     = ctrl.wb_from_mem ? dm_rdata : alu_y;
    assign reg_commit = ctrl.reg_write && !rst && (dst != 5'd0);

    assign pc_plus4   = s_q.pc + 32'd4;
    assign br_target  = pc_plus4 + {imm_sx[29:0], 2'b00};
    assign jmp_target = {pc_plus4[31:28], instr[25:0], 2'b00};
    assign taken      = ctrl.branch && alu_zero;

    always_comb begin
        s_d = s_q;
        if (rst)            s_d.pc = '0;
        else if (ctrl.jump) s_d.pc = jmp_target;
        else if (taken)     s_d.pc = br_target;
        else                s_d.pc = pc_plus4;
    end

    always_ff @(posedge clk) s_q <= s_d;

    assign pc_o         = s_q.pc;
    assign rf_we_o      = reg_commit;
    assign rf_waddr_o   = dst;
    assign rf_wdata_o   = wb_val;
    assign dmem_we_o    = core_store;
    assign dmem_addr_o  = alu_y;
    assign dmem_wdata_o = rt_val;

    logic unused_bits;
    assign unused_bits = ^{instr[10:6]};

    assert_reset_pc_R1: assert property (@(posedge clk)
        rst |=> s_q.pc == 32'd0);

    assert_seq_pc_R2: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.jump && !taken) |=> s_q.pc == $past(s_q.pc) + 32'd4);

    assert_store_no_regwrite_R5: assert property (@(posedge clk) disable iff (rst)
        dmem_we_o |-> !rf_we_o);

    assert_jump_target_R7: assert property (@(posedge clk) disable iff (rst)
        ctrl.jump |=> s_q.pc[27:0] == {$past(instr[25:0]), 2'b00});

    assert_illegal_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        ctrl.illegal |-> (!rf_we_o && !dmem_we_o));
endmodule

// File: tb/sc_cpu_core_tb_top.sv
module sc_cpu_core_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        load_we = 1'b0;
    logic        load_dmem = 1'b0;
    logic [7:0]  load_addr = '0;
    logic [31:0] load_data = '0;
    logic [31:0] pc_o, rf_wdata_o, dmem_addr_o, dmem_wdata_o;
    logic [4:0]  rf_waddr_o;
    logic        rf_we_o, dmem_we_o;

    int checks = 0;
    int fails  = 0;
    bit running = 1'b0;

    always #5 clk = ~clk;

    sc_cpu_core dut_i (
        .clk(clk), .rst(rst), .load_we(load_we), .load_dmem(load_dmem),
        .load_addr(load_addr), .load_data(load_data), .pc_o(pc_o),
        .rf_we_o(rf_we_o), .rf_waddr_o(rf_waddr_o), .rf_wdata_o(rf_wdata_o),
        .dmem_we_o(dmem_we_o), .dmem_addr_o(dmem_addr_o), .dmem_wdata_o(dmem_wdata_o)
    );

    typedef struct {
        logic [31:0] pc;
        logic        rwe;
        logic [4:0]  ra;
        logic [31:0] rd;
        logic        dwe;
        logic [31:0] da;
        logic [31:0] dd;
        string       req;
    } item_t;

    item_t sb_q[$];

    function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
        return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
    endfunction
    function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, logic [15:0] imm);
        return {op, 5'(rs), 5'(rt), imm};
    endfunction

    task automatic load_word(input bit to_dmem, input int idx, input logic [31:0] w);
        @(negedge clk);
        load_we = 1'b1; load_dmem = to_dmem; load_addr = 8'(idx); load_data = w;
        @(negedge clk);
        load_we = 1'b0;
    endtask

    task automatic expect_item(input logic [31:0] pc, input logic rwe, input int ra,
                               input logic [31:0] rd, input logic dwe,
                               input logic [31:0] da, input logic [31:0] dd, input string req);
        item_t it;
        it.pc = pc; it.rwe = rwe; it.ra = 5'(ra); it.rd = rd;
        it.dwe = dwe; it.da = da; it.dd = dd; it.req = req;
        sb_q.push_back(it);
    endtask

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    // Monitor: one expected item per falling edge while the program runs.
    always @(negedge clk) begin
        if (running && !rst && sb_q.size() > 0) begin
            item_t e;
            e = sb_q.pop_front();
            check(pc_o == e.pc, {e.req, " pc"}, pc_o, e.pc);
            check(rf_we_o == e.rwe, {e.req, " rf_we"}, 32'(rf_we_o), 32'(e.rwe));
            if (e.rwe && rf_we_o) begin
                check(rf_waddr_o == e.ra, {e.req, " rf_waddr"}, 32'(rf_waddr_o), 32'(e.ra));
                check(rf_wdata_o == e.rd, {e.req, " rf_wdata"}, rf_wdata_o, e.rd);
            end
            check(dmem_we_o == e.dwe, {e.req, " dmem_we"}, 32'(dmem_we_o), 32'(e.dwe));
            if (e.dwe && dmem_we_o) begin
                check(dmem_addr_o == e.da, {e.req, " dmem_addr"}, dmem_addr_o, e.da);
                check(dmem_wdata_o == e.dd, {e.req, " dmem_wdata"}, dmem_wdata_o, e.dd);
            end
        end
    end

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : driver
        logic [31:0] prog [24];
        prog[0]  = enc_i(6'h23, 0, 1, 16'd0);       // lw r1,0(r0)
        prog[1]  = enc_i(6'h23, 0, 2, 16'd4);       // lw r2,4(r0)
        prog[2]  = enc_i(6'h23, 0, 3, 16'd8);       // lw r3,8(r0)
        prog[3]  = enc_r(1, 2, 4, 6'h20);           // add r4
        prog[4]  = enc_r(1, 2, 5, 6'h22);           // sub r5
        prog[5]  = enc_r(1, 2, 6, 6'h24);           // and r6
        prog[6]  = enc_r(1, 2, 7, 6'h25);           // or r7
        prog[7]  = enc_r(3, 1, 8, 6'h2A);           // slt r8 = (-3<7)
        prog[8]  = enc_r(1, 3, 9, 6'h2A);           // slt r9 = (7<-3)
        prog[9]  = enc_r(1, 2, 0, 6'h20);           // add r0 (dropped)
        prog[10] = enc_i(6'h2B, 0, 0, 16'd12);      // sw r0,12(r0)
        prog[11] = enc_i(6'h23, 4, 10, 16'hFFFC);   // lw r10,-4(r4)
        prog[12] = enc_i(6'h04, 1, 2, 16'd5);       // beq not taken
        prog[13] = enc_i(6'h04, 6, 2, 16'd2);       // beq taken -> 0x40
        prog[14] = enc_r(1, 1, 11, 6'h20);          // skipped
        prog[15] = enc_r(1, 1, 11, 6'h20);          // skipped
        prog[16] = 32'hFC00_0000;                   // unknown opcode
        prog[17] = enc_r(1, 2, 12, 6'h3F);          // unknown funct
        prog[18] = {6'h02, 26'd21};                 // j 0x54
        prog[19] = enc_i(6'h2B, 0, 1, 16'd0);       // skipped
        prog[20] = enc_i(6'h2B, 0, 1, 16'd0);       // skipped
        prog[21] = enc_i(6'h2B, 0, 10, 16'd16);     // sw r10,16(r0)
        prog[22] = enc_i(6'h23, 0, 11, 16'd16);     // lw r11,16(r0)
        prog[23] = enc_i(6'h04, 0, 0, 16'hFFFF);    // beq r0,r0,-1 spin

        // R10: loader fills both memories during reset
        for (int i = 0; i < 24; i++) load_word(1'b0, i, prog[i]);
        load_word(1'b1, 0, 32'd7);
        load_word(1'b1, 1, 32'd5);
        load_word(1'b1, 2, 32'hFFFF_FFFD);

        // R1: reset state
        @(negedge clk);
        check(pc_o == 32'd0, "R1 reset pc", pc_o, 32'd0);
        check(!rf_we_o && !dmem_we_o, "R1 no writes in reset", 32'({rf_we_o, dmem_we_o}), 32'd0);

        expect_item(32'h00, 1, 1, 32'd7, 0, 0, 0, "R4 R10 lw r1");
        expect_item(32'h04, 1, 2, 32'd5, 0, 0, 0, "R4 R2 lw r2");
        expect_item(32'h08, 1, 3, 32'hFFFF_FFFD, 0, 0, 0, "R4 lw r3");
        expect_item(32'h0C, 1, 4, 32'd12, 0, 0, 0, "R3 add");
        expect_item(32'h10, 1, 5, 32'd2, 0, 0, 0, "R3 sub");
        expect_item(32'h14, 1, 6, 32'd5, 0, 0, 0, "R3 and");
        expect_item(32'h18, 1, 7, 32'd7, 0, 0, 0, "R3 or");
        expect_item(32'h1C, 1, 8, 32'd1, 0, 0, 0, "R3 slt true");
        expect_item(32'h20, 1, 9, 32'd0, 0, 0, 0, "R3 slt false");
        expect_item(32'h24, 0, 0, 0, 0, 0, 0, "R8 write r0 dropped");
        expect_item(32'h28, 0, 0, 0, 1, 32'd12, 32'd0, "R5 R8 sw r0");
        expect_item(32'h2C, 1, 10, 32'hFFFF_FFFD, 0, 0, 0, "R4 negative offset");
        expect_item(32'h30, 0, 0, 0, 0, 0, 0, "R6 beq not taken");
        expect_item(32'h34, 0, 0, 0, 0, 0, 0, "R6 beq taken");
        expect_item(32'h40, 0, 0, 0, 0, 0, 0, "R6 R9 target, unknown opcode");
        expect_item(32'h44, 0, 0, 0, 0, 0, 0, "R9 unknown funct");
        expect_item(32'h48, 0, 0, 0, 0, 0, 0, "R9 pc+4 then jump");
        expect_item(32'h54, 0, 0, 0, 1, 32'd16, 32'hFFFF_FFFD, "R7 R5 jump target sw");
        expect_item(32'h58, 1, 11, 32'hFFFF_FFFD, 0, 0, 0, "R4 R5 load stored word");
        for (int i = 0; i < 4; i++)
            expect_item(32'h5C, 0, 0, 0, 0, 0, 0, "R6 backward branch");

        @(posedge clk);
        rst <= 1'b0;
        running = 1'b1;
        wait (sb_q.size() == 0);
        @(negedge clk);
        running = 1'b0;

        // R1: reset in mid-run
        @(posedge clk);
        rst <= 1'b1;
        @(posedge clk);
        @(negedge clk);
        check(pc_o == 32'd0, "R1 mid-run reset pc", pc_o, 32'd0);
        check(!rf_we_o && !dmem_we_o, "R1 mid-run reset no writes",
              32'({rf_we_o, dmem_we_o}), 32'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule